// File: doc/BRIEF.md
# Sixteen-Bit Prescaled Event Timer

This block is a general-purpose 16-bit timer held behind a plain synchronous register port. Software programs a power-of-two divide code, a count direction, a reload limit and an optional single-shot behaviour, then starts and stops it with a command word. Each divided clock pulse moves the counter by one. In down mode, passing below zero reloads the counter from the limit and raises an underflow flag. In up mode, reaching the limit wraps the counter to zero and raises a wrap flag.

The two event flags each have an enable bit and a write-one set port and a write-one clear port. A single level interrupt line is high whenever an enabled flag is set. The current count can be read at any time. It can be loaded while the timer is stopped, so the operating system uses the block both as a free-running time base and as a programmable next-event alarm.

The bus uses word addresses: the byte offset divided by four. Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `tick_timer16`

## Requirements
- R1: After reset the control, limit, count, enable and flag registers all read zero, the counter is stopped and `irq_o` is low.
- R2: Word addresses are: control 0, command 1, enable 3, flags 4, flag-set 5, flag-clear 6, limit 7, count 9. Control holds the divide code in bits 27:24, the source select in bits 17:16, single-shot in bit 4 and the direction in bits 1:0, and it reads back as written. The command, flag-set and flag-clear addresses read zero.
- R3: A command write with bit 0 set starts the counter and one with bit 1 set stops it. When both bits are set, stop wins. A stopped counter never moves.
- R4: While running, the counter steps once every 2^code clock cycles. The first step lands 2^code edges after the start edge, because every start clears the divider.
- R5: In down mode (direction code 1) each step decrements the count. A step taken at zero instead reloads the count from the limit and sets flag bit 1 (underflow).
- R6: With any other direction code, each step increments the count. A step taken at a count equal to the limit instead writes zero and sets flag bit 0 (wrap).
- R7: With single-shot set in down mode, the underflow step reloads the limit and also stops the counter, which then holds the limit value.
- R8: A write to the count address loads the count only while the counter is stopped. While it runs, such a write is ignored.
- R9: Writing 1 to a bit at the flag-set address sets that flag. Writing 1 to a bit at the flag-clear address clears it. A hardware event on the same edge beats the clear. Writes to the flag address itself are ignored.
- R10: `irq_o` is high exactly when some flag bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register |
| irq_o | output | 1 | Level interrupt request |

## Verification
A stuck or missing divider pulse shows up as a count that drifts from the predicted value. This is visible at the next count read after a run of known length, and within one divide period when the code is small. A wrong run state, such as a lost single-shot halt or a stop that loses to a start, keeps the count moving, so it shows up as soon as the count is read back. Flag or enable corruption reaches `irq_o` combinationally, in the same cycle as the register edge that caused it.

// File: rtl/tt_pkg.sv
package tt_pkg;
   // word addresses (byte offset / 4)
   localparam int unsigned WA_CTRL   = 0;
   localparam int unsigned WA_CMD    = 1;
   localparam int unsigned WA_IEN    = 3;
   localparam int unsigned WA_FLAGS  = 4;
   localparam int unsigned WA_FSET   = 5;
   localparam int unsigned WA_FCLR   = 6;
   localparam int unsigned WA_LIMIT  = 7;
   localparam int unsigned WA_COUNT  = 9;

   // control field placement
   localparam int unsigned CTL_DIR_LSB  = 0;
   localparam int unsigned CTL_DIR_W    = 2;
   localparam int unsigned CTL_SHOT_BIT = 4;
   localparam int unsigned CTL_SRC_LSB  = 16;
   localparam int unsigned CTL_SRC_W    = 2;
   localparam int unsigned CTL_PSC_LSB  = 24;

   // command bits
   localparam int unsigned CMD_GO_BIT   = 0;
   localparam int unsigned CMD_HALT_BIT = 1;

   // flag bits
   localparam int unsigned FLG_WRAP  = 0;
   localparam int unsigned FLG_UNDER = 1;

   typedef enum logic [1:0] {
      DIR_UP    = 2'd0,
      DIR_DOWN  = 2'd1,
      DIR_UP_B  = 2'd2,
      DIR_UP_C  = 2'd3
   } dir_e;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int unsigned PSC_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [PSC_W-1:0] code_i,
   output logic             tick_o
);
   localparam int unsigned DIV_W = (1 << PSC_W) - 1;

   generate
      if (PSC_W < 1 || PSC_W > 5) begin : g_bad_psc
         $error("tt_prescaler: PSC_W must lie in 1..5");
      end
   endgenerate

   logic [DIV_W-1:0] acc_q;
   logic [DIV_W-1:0] mask;

   assign mask   = ~({DIV_W{1'b1}} << code_i);
   assign tick_o = run_i && (acc_q == mask);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else if (restart_i || !run_i || tick_o) begin
         acc_q <= '0;
      end else begin
         acc_q <= acc_q + 1'b1;
      end
   end
endmodule

// File: rtl/tt_count_core.sv
module tt_count_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_i,
   input  logic             halt_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   input  logic             down_i,
   input  logic             oneshot_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             run_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             under_o,
   output logic             wrap_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("tt_count_core: CNT_W must be at least 2");
      end
   endgenerate

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   assign under_o = tick_i && down_i && (cnt_q == '0);
   assign wrap_o  = tick_i && !down_i && (cnt_q == limit_i);
   assign run_o   = run_q;
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
      end else if (halt_i) begin
         run_q <= 1'b0;
      end else if (go_i) begin
         run_q <= 1'b1;
      end else if (under_o && oneshot_i) begin
         run_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i && !run_q) begin
         cnt_q <= load_val_i;
      end else if (tick_i) begin
         if (under_o) begin
            cnt_q <= limit_i;
         end else if (wrap_o) begin
            cnt_q <= '0;
         end else if (down_i) begin
            cnt_q <= cnt_q - 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tt_flags.sv
module tt_flags #(
   parameter int unsigned FLG_N = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ien_we_i,
   input  logic             set_we_i,
   input  logic             clr_we_i,
   input  logic [FLG_N-1:0] wdata_i,
   input  logic [FLG_N-1:0] hw_evt_i,
   output logic [FLG_N-1:0] flags_o,
   output logic [FLG_N-1:0] ien_o,
   output logic             irq_o
);
   logic [FLG_N-1:0] ien_q;
   logic [FLG_N-1:0] flg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ien_q <= '0;
      end else if (ien_we_i) begin
         ien_q <= wdata_i;
      end
   end

   generate
      for (genvar i = 0; i < FLG_N; i++) begin : g_flag
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               flg_q[i] <= 1'b0;
            end else begin
               flg_q[i] <= (flg_q[i] & ~(clr_we_i & wdata_i[i]))
                         | (set_we_i & wdata_i[i])
                         | hw_evt_i[i];
            end
         end
      end
   endgenerate

   assign flags_o = flg_q;
   assign ien_o   = ien_q;
   assign irq_o   = |(flg_q & ien_q);
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16 #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 4,
   parameter int unsigned FLG_N  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);
   import tt_pkg::*;

   generate
      if (DATA_W < CTL_PSC_LSB + PSC_W || DATA_W < CNT_W) begin : g_bad_data
         $error("tick_timer16: DATA_W too narrow for the fields");
      end
      if ((1 << ADDR_W) <= WA_COUNT) begin : g_bad_addr
         $error("tick_timer16: ADDR_W cannot reach every register");
      end
      if (FLG_N < 2) begin : g_bad_flg
         $error("tick_timer16: FLG_N must be at least 2");
      end
   endgenerate

   // write decode
   logic we_ctrl, we_cmd, we_ien, we_fset, we_fclr, we_limit, we_count;
   assign we_ctrl  = bus_we_i && (bus_addr_i == ADDR_W'(WA_CTRL));
   assign we_cmd   = bus_we_i && (bus_addr_i == ADDR_W'(WA_CMD));
   assign we_ien   = bus_we_i && (bus_addr_i == ADDR_W'(WA_IEN));
   assign we_fset  = bus_we_i && (bus_addr_i == ADDR_W'(WA_FSET));
   assign we_fclr  = bus_we_i && (bus_addr_i == ADDR_W'(WA_FCLR));
   assign we_limit = bus_we_i && (bus_addr_i == ADDR_W'(WA_LIMIT));
   assign we_count = bus_we_i && (bus_addr_i == ADDR_W'(WA_COUNT));

   wire unused_wdata = ^bus_wdata_i;

   // control and limit registers
   logic [PSC_W-1:0]     psc_q;
   logic [CTL_SRC_W-1:0] src_q;
   logic                 shot_q;
   dir_e                 dir_q;
   logic [CNT_W-1:0]     limit_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         psc_q   <= '0;
         src_q   <= '0;
         shot_q  <= 1'b0;
         dir_q   <= DIR_UP;
         limit_q <= '0;
      end else begin
         if (we_ctrl) begin
            psc_q  <= bus_wdata_i[CTL_PSC_LSB +: PSC_W];
            src_q  <= bus_wdata_i[CTL_SRC_LSB +: CTL_SRC_W];
            shot_q <= bus_wdata_i[CTL_SHOT_BIT];
            dir_q  <= dir_e'(bus_wdata_i[CTL_DIR_LSB +: CTL_DIR_W]);
         end
         if (we_limit) begin
            limit_q <= bus_wdata_i[CNT_W-1:0];
         end
      end
   end

   // commands
   logic go, halt, down;
   assign go   = we_cmd && bus_wdata_i[CMD_GO_BIT];
   assign halt = we_cmd && bus_wdata_i[CMD_HALT_BIT];
   assign down = (dir_q == DIR_DOWN);

   logic             run_w, tick_w, under_w, wrap_w;
   logic [CNT_W-1:0] cnt_w;
   logic [FLG_N-1:0] flags_w, ien_w, hw_evt;

   tt_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_w),
      .restart_i (go && !halt),
      .code_i    (psc_q),
      .tick_o    (tick_w)
   );

   tt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .go_i       (go),
      .halt_i     (halt),
      .load_i     (we_count),
      .load_val_i (bus_wdata_i[CNT_W-1:0]),
      .tick_i     (tick_w),
      .down_i     (down),
      .oneshot_i  (shot_q),
      .limit_i    (limit_q),
      .run_o      (run_w),
      .cnt_o      (cnt_w),
      .under_o    (under_w),
      .wrap_o     (wrap_w)
   );

   always_comb begin
      hw_evt            = '0;
      hw_evt[FLG_UNDER] = under_w;
      hw_evt[FLG_WRAP]  = wrap_w;
   end

   tt_flags #(.FLG_N(FLG_N)) u_flags (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ien_we_i (we_ien),
      .set_we_i (we_fset),
      .clr_we_i (we_fclr),
      .wdata_i  (bus_wdata_i[FLG_N-1:0]),
      .hw_evt_i (hw_evt),
      .flags_o  (flags_w),
      .ien_o    (ien_w),
      .irq_o    (irq_o)
   );

   // read mux
   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(WA_CTRL)) begin
         bus_rdata_o[CTL_PSC_LSB +: PSC_W]     = psc_q;
         bus_rdata_o[CTL_SRC_LSB +: CTL_SRC_W] = src_q;
         bus_rdata_o[CTL_SHOT_BIT]             = shot_q;
         bus_rdata_o[CTL_DIR_LSB +: CTL_DIR_W] = dir_q;
      end else if (bus_addr_i == ADDR_W'(WA_IEN)) begin
         bus_rdata_o[FLG_N-1:0] = ien_w;
      end else if (bus_addr_i == ADDR_W'(WA_FLAGS)) begin
         bus_rdata_o[FLG_N-1:0] = flags_w;
      end else if (bus_addr_i == ADDR_W'(WA_LIMIT)) begin
         bus_rdata_o[CNT_W-1:0] = limit_q;
      end else if (bus_addr_i == ADDR_W'(WA_COUNT)) begin
         bus_rdata_o[CNT_W-1:0] = cnt_w;
      end
   end
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 4,
   parameter int unsigned FLG_N  = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_we_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic              irq_o,
   input logic              run,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  limit,
   input logic [PSC_W-1:0]  psc,
   input logic [1:0]        dir,
   input logic              shot,
   input logic [FLG_N-1:0]  flags,
   input logic [FLG_N-1:0]  ien
);
   logic cmd_wr, cnt_wr, clr_wr, is_down, at_zero_step;
   assign cmd_wr       = bus_we_i && (bus_addr_i == ADDR_W'(1));
   assign cnt_wr       = bus_we_i && (bus_addr_i == ADDR_W'(9));
   assign clr_wr       = bus_we_i && (bus_addr_i == ADDR_W'(6));
   assign is_down      = (dir == 2'd1);
   assign at_zero_step = tick && is_down && (cnt == '0);

   AST_HALT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_wr && bus_wdata_i[1] |=> !run);                              // R3
   AST_GO_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_wr && bus_wdata_i[0] && !bus_wdata_i[1] |=> run);            // R3
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run && !cnt_wr |=> $stable(cnt));                               // R8
   AST_PSC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick |=> (psc == '0) || !tick);                                  // R4
   AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick && is_down && (cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1)); // R5
   AST_UNDER_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      at_zero_step |=> (cnt == $past(limit)) && flags[1]);             // R5
   AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick && !is_down && (cnt == limit) |=> (cnt == '0) && flags[0]); // R6
   AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      at_zero_step && shot && !cmd_wr |=> !run);                       // R7
   AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_wr && bus_wdata_i[1] && !at_zero_step |=> !flags[1]);        // R9
   AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ien == '0) |-> !irq_o);                                         // R10
endmodule

bind tick_timer16 tt_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .FLG_N(FLG_N)
) u_tt_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_addr_i  (bus_addr_i),
   .bus_we_i    (bus_we_i),
   .bus_wdata_i (bus_wdata_i),
   .irq_o       (irq_o),
   .run         (run_w),
   .tick        (tick_w),
   .cnt         (cnt_w),
   .limit       (limit_q),
   .psc         (psc_q),
   .dir         (dir_q),
   .shot        (shot_q),
   .flags       (flags_w),
   .ien         (ien_w)
);

// File: tb/test_tick_timer16.sv
`timescale 1ns/10ps
module test_tick_timer16;
   localparam int A_CTRL = 0, A_CMD = 1, A_IEN = 3, A_FLG = 4;
   localparam int A_FSET = 5, A_FCLR = 6, A_LIM = 7, A_CNT = 9;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [3:0]  bus_addr_i = '0;
   logic        bus_we_i = 1'b0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        irq_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk_i = ~clk_i;

   tick_timer16 i_tick_timer16 (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bus_addr_i  (bus_addr_i),
      .bus_we_i    (bus_we_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .irq_o       (irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // drive at a falling edge, return at the next falling edge
   task automatic wr(input int a, input logic [31:0] d);
      bus_addr_i = 4'(a); bus_wdata_i = d; bus_we_i = 1'b1;
      @(posedge clk_i); #2;
      bus_we_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk_i); #2; end
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr_i = 4'(a); #0.1; d = bus_rdata_o;
   endtask

   function automatic logic [31:0] ctrl_word(input int code, input bit shot, input int dir);
      return (32'(code) << 24) | (32'(shot) << 4) | 32'(dir & 3);
   endfunction

   // expected behaviour of a run with a given number of divided steps
   task automatic predict(input int steps, input bit down, input bit shot,
                          input logic [15:0] lim, inout logic [15:0] c,
                          inout bit uf, inout bit of);
      for (int i = 0; i < steps; i++) begin
         if (down) begin
            if (c == 16'd0) begin
               c = lim; uf = 1'b1;
               if (shot) break;
            end else c = c - 16'd1;
         end else begin
            if (c == lim) begin c = 16'd0; of = 1'b1; end
            else c = c + 16'd1;
         end
      end
   endtask

   task automatic run_case(input int code, input int dir, input bit shot,
                           input logic [15:0] lim, input logic [15:0] c0,
                           input int w, input string tag);
      logic [31:0] v;
      logic [15:0] c;
      bit uf, of;
      c = c0; uf = 1'b0; of = 1'b0;
      wr(A_CMD, 32'h2);
      wr(A_FCLR, 32'h3);
      wr(A_CTRL, ctrl_word(code, shot, dir));
      wr(A_LIM, 32'(lim));
      wr(A_CNT, 32'(c0));
      wr(A_CMD, 32'h1);
      idle(w - 1);
      wr(A_CMD, 32'h2);
      predict(w >> code, dir == 1, shot, lim, c, uf, of);
      rd(A_CNT, v);
      check({tag, " count"}, v, 32'(c));
      rd(A_FLG, v);
      check({tag, " flags"}, v, {30'd0, uf, of});
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd7311));
      repeat (3) @(posedge clk_i);
      #2; rst_ni = 1'b1;

      // R1: reset state
      rd(A_CTRL, v); check("R1 ctrl", v, 0);
      rd(A_CNT, v);  check("R1 count", v, 0);
      rd(A_LIM, v);  check("R1 limit", v, 0);
      rd(A_IEN, v);  check("R1 enable", v, 0);
      rd(A_FLG, v);  check("R1 flags", v, 0);
      check("R1 irq", 32'(irq_o), 0);
      idle(4);
      rd(A_CNT, v);  check("R1 stopped", v, 0);

      // R2: field readback and write-only addresses
      wr(A_CTRL, 32'h0A03_0013);
      rd(A_CTRL, v); check("R2 ctrl", v, 32'h0A03_0013);
      wr(A_LIM, 32'h0000_1234);
      rd(A_LIM, v);  check("R2 limit", v, 32'h1234);
      rd(A_CMD, v);  check("R2 cmd reads 0", v, 0);
      rd(A_FSET, v); check("R2 fset reads 0", v, 0);
      rd(A_FCLR, v); check("R2 fclr reads 0", v, 0);

      // R3: stop wins over start
      wr(A_CTRL, ctrl_word(0, 0, 1));
      wr(A_CNT, 32'd5);
      wr(A_CMD, 32'h3);
      idle(5);
      rd(A_CNT, v);  check("R3 stop wins", v, 5);

      // R4 / R8: divide by 4, first step four edges after start, load ignored when running
      wr(A_CTRL, ctrl_word(2, 0, 1));
      wr(A_CNT, 32'd100);
      wr(A_CMD, 32'h1);
      idle(3);
      rd(A_CNT, v);  check("R4 no early step", v, 100);
      idle(1);
      rd(A_CNT, v);  check("R4 first step", v, 99);
      wr(A_CNT, 32'd7);
      rd(A_CNT, v);  check("R8 load while running ignored", v, 99);
      idle(3);
      rd(A_CNT, v);  check("R4 second period", v, 98);
      wr(A_CMD, 32'h2);
      wr(A_CNT, 32'd40);
      rd(A_CNT, v);  check("R8 load while stopped", v, 40);

      // R7 / R5: single shot underflow
      wr(A_FCLR, 32'h3);
      wr(A_CTRL, ctrl_word(0, 1, 1));
      wr(A_LIM, 32'd20);
      wr(A_CNT, 32'd2);
      wr(A_CMD, 32'h1);
      idle(10);
      rd(A_CNT, v);  check("R7 holds limit", v, 20);
      rd(A_FLG, v);  check("R5 underflow flag", v, 2);

      // R10 / R9: masking and flag ports
      check("R10 masked", 32'(irq_o), 0);
      wr(A_IEN, 32'h2);
      check("R10 enabled", 32'(irq_o), 1);
      wr(A_FCLR, 32'h2);
      rd(A_FLG, v);  check("R9 clear", v, 0);
      check("R10 cleared", 32'(irq_o), 0);
      wr(A_FSET, 32'h1);
      rd(A_FLG, v);  check("R9 set", v, 1);
      check("R10 other mask", 32'(irq_o), 0);
      wr(A_IEN, 32'h3);
      check("R10 wrap enabled", 32'(irq_o), 1);
      wr(A_FLG, 32'h0);
      rd(A_FLG, v);  check("R9 flag write ignored", v, 1);
      wr(A_IEN, 32'h0);

      // R6: up count wraps at limit
      wr(A_FCLR, 32'h3);
      wr(A_CTRL, ctrl_word(0, 0, 0));
      wr(A_LIM, 32'd17);
      wr(A_CNT, 32'd15);
      wr(A_CMD, 32'h1);
      idle(2);
      wr(A_CMD, 32'h2);
      rd(A_CNT, v);  check("R6 wrap to zero", v, 0);
      rd(A_FLG, v);  check("R6 wrap flag", v, 1);

      // R9: hardware event beats clear on the same edge
      wr(A_FCLR, 32'h3);
      wr(A_CTRL, ctrl_word(0, 0, 1));
      wr(A_LIM, 32'd30);
      wr(A_CNT, 32'd0);
      wr(A_CMD, 32'h1);
      wr(A_FCLR, 32'h2);
      wr(A_CMD, 32'h2);
      rd(A_FLG, v);  check("R9 event beats clear", v, 2);

      // R4 R5 R6 R7: random runs
      for (int k = 0; k < 30; k++) begin
         int code, dir, w;
         bit shot;
         logic [15:0] lim, c0;
         code = int'($urandom % 3);
         dir  = int'($urandom % 4);
         shot = 1'($urandom % 2);
         lim  = 16'(15 + $urandom % 40);
         c0   = 16'($urandom % (32'(lim) + 1));
         w    = 1 + int'($urandom % 200);
         run_case(code, dir, shot, lim, c0, w, "R4 R5 R6 R7 random");
      end
      run_case(0, 1, 0, 16'hFFFF, 16'h000F, 40, "R5 full limit");
      run_case(1, 2, 0, 16'h000F, 16'h000F, 9, "R6 alt up code");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule